// File: doc/BRIEF.md
# Bubble-Through Marker FIFO

This block is a small first-in first-out buffer. It is a chain of word stages, not a pointer-addressed memory. Each stage holds one data word and a marker bit that says whether the stage is occupied. A word moves one stage toward the output whenever the next stage is vacant. Valid words therefore collect at the output end, and vacant stages drift back toward the input. The input ready flag is simply "first stage vacant". The output ready flag is simply "last stage occupied".

A producer loads a word with a rising edge on its strobe. A consumer discards the word shown at the output with a falling edge on its strobe. Both strobes are plain levels sampled on the system clock, and the block finds the edges itself. An output-disable input blocks unloading and forces the data outputs to zero. A master clear vacates every stage but leaves the stored words in place.

Top module: `bubble_fifo`

## Requirements
- R1: The buffer holds DEPTH (default 16) words of WIDTH (default 4) bits. Once DEPTH words are held and none is unloaded, `in_rdy` stays 0 and `out_rdy` stays 1.
- R2: A word on `din` is stored when `shin` is sampled 1 after being sampled 0 on the previous clock and `in_rdy` is 1. Holding `shin` at 1 stores only one word; `shin` must return to 0 before another word is taken.
- R3: After a word is stored into an otherwise empty buffer, `in_rdy` is 0 for exactly one clock and then returns to 1 when the word moves to the second stage.
- R4: A word advances at most one stage per clock, and a stage vacated on a clock cannot be refilled on that same clock. In an empty buffer, `out_rdy` rises 15 clocks (DEPTH-1) after the clock that stored the word into the first stage.
- R5: A `shin` rising edge while `in_rdy` is 0 is ignored. No word is added and no stored word is changed.
- R6: Words leave in the order they were stored. An unload happens when `shout` is sampled 0 after being sampled 1 on the previous clock, `out_off` is 0 and `out_rdy` is 1. `out_rdy` is 0 on the clock after an unload and rises again once the next word reaches the last stage. While `out_rdy` is 1 and `out_off` is 0, `dout` shows the oldest word.
- R7: An unload strobe is ignored while `out_rdy` is 0. It is also ignored while `out_off` is 1.
- R8: If `out_off` is sampled 0 after being sampled 1, while `shout` is sampled 0, that is treated as an unload strobe. One word is discarded.
- R9: While `out_off` is 1, `dout` is all zeros.
- R10: While `clear` is 1, all markers are cleared on each clock, so afterwards `in_rdy` is 1 and `out_rdy` is 0. The stored words are not altered, so `dout` still shows the previous last-stage word. `shin` must be 0 during `clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| clear | input | 1 | Master clear, active high, synchronous |
| shin | input | 1 | Load strobe; a rising level stores `din` |
| din | input | WIDTH | Word to store |
| in_rdy | output | 1 | First stage vacant |
| shout | input | 1 | Unload strobe; a falling level discards the output word |
| out_off | input | 1 | Output disable: blocks unloading and zeroes `dout` |
| dout | output | WIDTH | Oldest word, or zero while disabled |
| out_rdy | output | 1 | Last stage occupied |

## Verification
The hardest situation to reach is the unload caused by re-enabling the output while the unload strobe is already low. It needs `out_off` to fall in exactly the cycles where `shout` is held at 0 and a word sits in the last stage. A directed sequence arranges this deliberately. The random phase also toggles `out_off` often enough to hit it repeatedly. The bench predicts each store and unload from the sampled port levels, one clock ahead, and keeps a queue model. The full-buffer rejection and the 15-clock fall-through are forced with directed fills on an idle consumer.

// File: rtl/bubble_fifo.sv
module bubble_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             shin,
  input  logic [WIDTH-1:0] din,
  output logic             in_rdy,
  input  logic             shout,
  input  logic             out_off,
  output logic [WIDTH-1:0] dout,
  output logic             out_rdy
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] mark;
  logic [DEPTH-1:0] enter;
  logic [DEPTH-1:0] leave;
  logic [WIDTH-1:0] word [DEPTH];
  logic             shin_q, shout_q, off_q;
  logic             load, dump;

  assign in_rdy  = ~mark[0];
  assign out_rdy = mark[LAST];
  assign dout    = out_off ? '0 : word[LAST];

  assign load = shin & ~shin_q & ~mark[0];
  assign dump = ~shout & ~out_off & (shout_q | off_q) & mark[LAST];

  always_ff @(posedge clk) begin
    if (clear) begin
      shin_q  <= 1'b0;
      shout_q <= 1'b0;
      off_q   <= 1'b0;
    end else begin
      shin_q  <= shin;
      shout_q <= shout;
      off_q   <= out_off;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic             m;
    logic [WIDTH-1:0] w;
    logic [WIDTH-1:0] src;

    if (i == 0) begin : g_head
      assign enter[i] = load;
      assign src      = din;
    end else begin : g_body
      assign enter[i] = mark[i-1] & ~mark[i];
      assign src      = word[i-1];
    end

    if (i == LAST) begin : g_tail
      assign leave[i] = dump;
    end else begin : g_pass
      assign leave[i] = mark[i] & ~mark[i+1];
    end

    always_ff @(posedge clk) begin
      if (clear) m <= 1'b0;
      else       m <= (m & ~leave[i]) | enter[i];
      if (!clear && enter[i]) w <= src;
    end

    assign mark[i] = m;
    assign word[i] = w;
  end
endmodule

// File: rtl/bubble_fifo_chk.sv
module bubble_fifo_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clear,
  input logic             shin,
  input logic             shout,
  input logic             out_off,
  input logic             in_rdy,
  input logic             out_rdy,
  input logic [WIDTH-1:0] dout
);
  // R10
  reset_state_chk: assert property (@(posedge clk) disable iff (clear)
    $past(clear) |-> (in_rdy && !out_rdy));

  // R2
  in_fall_chk: assert property (@(posedge clk) disable iff (clear)
    (!$past(clear) && $fell(in_rdy)) |-> ($past(shin) && !$past(shin, 2)));

  // R6
  out_fall_chk: assert property (@(posedge clk) disable iff (clear)
    (!$past(clear) && $fell(out_rdy)) |-> ($past(!shout) && $past(!out_off)));

  // R6
  dout_stable_chk: assert property (@(posedge clk) disable iff (clear)
    (!$past(clear) && out_rdy && $past(out_rdy) && !out_off && $past(!out_off))
      |-> $stable(dout));
endmodule

bind bubble_fifo bubble_fifo_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .clear(clear), .shin(shin), .shout(shout), .out_off(out_off),
  .in_rdy(in_rdy), .out_rdy(out_rdy), .dout(dout)
);

// File: tb/tb_bubble_fifo.sv
`timescale 1ns/1ps
module tb_bubble_fifo;
  localparam int DEPTH = 16;
  localparam int WIDTH = 4;

  logic clk = 1'b0, clear = 1'b1, shin = 1'b0, shout = 1'b1, out_off = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic in_rdy, out_rdy;
  logic [WIDTH-1:0] dout;
  int n_cmp = 0, n_bad = 0;
  logic [WIDTH-1:0] q[$];

  always #2.5 clk = ~clk;

  bubble_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk(clk), .clear(clear), .shin(shin), .din(din), .in_rdy(in_rdy),
    .shout(shout), .out_off(out_off), .dout(dout), .out_rdy(out_rdy)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(logic [WIDTH-1:0] v);
    while (!in_rdy) @(negedge clk);
    din = v; shin = 1'b1; q.push_back(v);
    @(negedge clk); shin = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop_chk(string r);
    while (!out_rdy) @(negedge clk);
    chk(r, dout, q[0]);
    void'(q.pop_front());
    shout = 1'b0;
    @(negedge clk); shout = 1'b1;
    @(negedge clk);
  endtask

  function automatic logic [WIDTH-1:0] mix(int k);
    return WIDTH'((k * 7 + 3) ^ (k >> 2));
  endfunction

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    wait_cyc(3);
    clear = 1'b0;
    @(negedge clk);
    chk("R10 in_rdy after clear", in_rdy, 1);
    chk("R10 out_rdy after clear", out_rdy, 0);

    // R3 R4 fall-through timing
    din = 4'h5; shin = 1'b1; q.push_back(4'h5);
    @(negedge clk);
    chk("R3 in_rdy low after store", in_rdy, 0);
    shin = 1'b0;
    @(negedge clk);
    chk("R3 in_rdy back high", in_rdy, 1);
    wait_cyc(13);
    chk("R4 out_rdy before 15 clocks", out_rdy, 0);
    @(negedge clk);
    chk("R4 out_rdy at 15 clocks", out_rdy, 1);
    chk("R4 word at output", dout, 4'h5);
    pop_chk("R6 first word");
    chk("R6 out_rdy low after unload", out_rdy, 0);

    // R7 unload while empty
    shout = 1'b0; @(negedge clk); shout = 1'b1; @(negedge clk);
    push(4'h9);
    wait_cyc(20);
    pop_chk("R7 word after empty strobe");
    wait_cyc(20);
    chk("R7 nothing left", out_rdy, 0);

    // R9 R7 disable blocks unload
    push(4'h3); push(4'h4);
    wait_cyc(20);
    out_off = 1'b1; @(negedge clk);
    chk("R9 dout zero while disabled", dout, 0);
    shout = 1'b0; @(negedge clk); shout = 1'b1; @(negedge clk);
    out_off = 1'b0; @(negedge clk);
    chk("R7 blocked unload kept word", dout, 4'h3);
    pop_chk("R7 order after block");

    // R8 re-enable with strobe low
    wait_cyc(20);
    out_off = 1'b1; @(negedge clk);
    shout = 1'b0; @(negedge clk);
    chk("R7 out_rdy held while disabled", out_rdy, 1);
    out_off = 1'b0; @(negedge clk);
    chk("R8 re-enable unloads", out_rdy, 0);
    void'(q.pop_front());
    shout = 1'b1;
    wait_cyc(20);
    chk("R8 single word unloaded", out_rdy, 0);

    // R2 held strobe stores once
    din = 4'h7; shin = 1'b1; q.push_back(4'h7);
    wait_cyc(30);
    shin = 1'b0;
    wait_cyc(20);
    pop_chk("R2 held strobe word");
    wait_cyc(20);
    chk("R2 only one word stored", out_rdy, 0);

    // R1 R5 full buffer
    for (int k = 0; k < DEPTH; k++) push(mix(k));
    wait_cyc(20);
    chk("R1 in_rdy low when full", in_rdy, 0);
    chk("R1 out_rdy high when full", out_rdy, 1);
    din = 4'hF; shin = 1'b1; @(negedge clk); shin = 1'b0; @(negedge clk);
    chk("R5 output unchanged by rejected store", dout, q[0]);
    while (q.size() > 0) pop_chk("R5 full drain order");
    wait_cyc(20);
    chk("R5 rejected word absent", out_rdy, 0);

    // R10 clear keeps storage
    push(4'hA);
    wait_cyc(20);
    chk("R10 word present", dout, 4'hA);
    clear = 1'b1; @(negedge clk); clear = 1'b0; @(negedge clk);
    chk("R10 out_rdy cleared", out_rdy, 0);
    chk("R10 in_rdy set", in_rdy, 1);
    chk("R10 storage kept", dout, 4'hA);
    q.delete();
    wait_cyc(20);
    chk("R10 stays empty", out_rdy, 0);
    push(4'h2);
    pop_chk("R10 reuse after clear");

    // random phase R6 R9
    for (int c = 0; c < 4000; c++) begin
      logic ns, no, nf;
      @(negedge clk);
      if (out_off) chk("R9 random disabled dout", dout, 0);
      else if (out_rdy) chk("R6 random output word", dout, q[0]);
      ns = ($urandom % 3 == 0) ? ~shin : shin;
      no = ($urandom % 3 == 0) ? ~shout : shout;
      nf = ($urandom % 16 == 0);
      if (ns && !shin && in_rdy) begin
        din = WIDTH'($urandom);
        q.push_back(din);
      end
      if (!no && !nf && (shout || out_off) && out_rdy) void'(q.pop_front());
      shin = ns; shout = no; out_off = nf;
    end
    @(negedge clk);
    shin = 1'b0; shout = 1'b1; out_off = 1'b0;
    @(negedge clk);
    while (q.size() > 0) pop_chk("R6 random drain");
    wait_cyc(20);
    chk("R6 model and buffer both empty", out_rdy, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule